// File: doc/BRIEF.md
# Arithmetic Fallback Unit

This block sits between the issue stage of a core and its integer adder and multiplier. Each accepted add or multiply request is served in one of two ways. If the native unit for the operation is usable, the block computes the result directly. If that unit is marked unusable, because it is over its temperature limit or carries a defect, the block computes the result by table lookup. The operands and a per-operation table base together form a memory address. The entry at that address holds the precomputed result.

The most recently used table entries sit in a small private direct-mapped cache. A lookup that hits in this cache answers without touching memory. A lookup that misses issues a single read on the memory port, writes the returned word into the cache and then forwards it as the result. The block handles one request at a time, so responses leave in the order the requests arrived. Each response carries a flag that names the path that produced it.

Top module: `arith_fb`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `rsp_valid_o` and `mem_req_o` are 0. The table cache is empty, so the first table-path request of any kind misses.
- R2: A request is accepted in a cycle where both `req_valid_i` and `req_ready_o` are 1. If the operation's native unit is available at that point, the cycle after acceptance shows `rsp_valid_o`=1, `rsp_lut_o`=0 and `rsp_data_o` equal to the zero-extended result. For `req_op_i`=0 the result is a+b; for `req_op_i`=1 it is a*b.
- R3: A request served by a native unit raises no memory read and leaves the table cache unchanged. A later table-path request with the same operation and operands therefore still misses.
- R4: An operation's native unit counts as unavailable when its bit is set in either `unit_hot_i` or `unit_bad_i`. Bit 0 covers add and bit 1 covers multiply. The value sampled at acceptance decides the path.
- R5: A table read goes to address {base, a, b}, where a sits in bits 7:4 and b in bits 3:0. The base is `ADD_BASE` (default 8'h10) for add and `MUL_BASE` (default 8'h20) for multiply, and it fills the upper address bits.
- R6: On a cache miss, `mem_req_o` rises two cycles after acceptance. It holds with a stable address until a cycle with `mem_rvalid_i`=1. The next cycle shows `rsp_valid_o`=1, `rsp_lut_o`=1 and `rsp_data_o` equal to the `mem_rdata_i` sampled with that `mem_rvalid_i`, while `mem_req_o` returns to 0.
- R7: On a cache hit, no memory read is issued. The cycle two cycles after acceptance shows `rsp_valid_o`=1, `rsp_lut_o`=1 and the cached result.
- R8: The cache has 16 direct-mapped entries indexed by a XOR b. Each entry is tagged with the full {op, a, b}. A fill replaces whatever the indexed entry held, including an entry that belongs to the other operation.
- R9: From the acceptance of a table-path request until its response cycle, `req_ready_o` is 0 and no response appears. `req_ready_o` is 1 again in the response cycle.
- R10: A `mem_rvalid_i` pulse while no read is outstanding produces no response and does not alter the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_op_i | input | 1 | Operation: 0 add, 1 multiply |
| req_a_i | input | OPW | First operand |
| req_b_i | input | OPW | Second operand |
| unit_hot_i | input | 2 | Over-temperature flag per native unit (bit 0 add, bit 1 multiply) |
| unit_bad_i | input | 2 | Defect mask per native unit (bit 0 add, bit 1 multiply) |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_data_o | output | 2*OPW | Result |
| rsp_lut_o | output | 1 | 1 when the table path produced the result |
| mem_req_o | output | 1 | Table read request, held until data returns |
| mem_addr_o | output | MEM_AW | Table read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 2*OPW | Read data |

## Verification
A corrupted tag or valid bit shows up as a hit-or-miss decision that differs from the reference model. A wrong decision appears on `mem_req_o` two cycles after acceptance, and a false hit also returns the wrong result in the same cycle. Corrupted cached data surfaces only when that entry is next hit, so the bench re-reads entries after conflicts and after stray memory strobes. A wrong path decision shows up in the first response cycle, through both the path flag and the one-cycle versus multi-cycle timing.

// File: rtl/arith_fb_pkg.sv
package arith_fb_pkg;
  typedef enum logic {OP_ADD = 1'b0, OP_MUL = 1'b1} fb_op_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_LOOK = 2'd1, ST_MISS = 2'd2} fb_state_e;
endpackage

// File: rtl/arith_fb_native.sv
module arith_fb_native import arith_fb_pkg::*; #(
  parameter int OPW = 4,
  localparam int RES_W = 2 * OPW
) (
  input  fb_op_e           op_i,
  input  logic [OPW-1:0]   a_i,
  input  logic [OPW-1:0]   b_i,
  output logic [RES_W-1:0] res_o
);
  logic [RES_W-1:0] a_ext, b_ext;
  assign a_ext = RES_W'(a_i);
  assign b_ext = RES_W'(b_i);

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_ext + b_ext;
      OP_MUL:  res_o = a_ext * b_ext;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/arith_fb_tcache.sv
module arith_fb_tcache #(
  parameter int OPW     = 4,
  parameter int ENTRIES = 16,
  localparam int RES_W  = 2 * OPW,
  localparam int KW     = 1 + 2 * OPW,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [KW-1:0]    key_i,
  output logic             hit_o,
  output logic [RES_W-1:0] data_o,
  input  logic             fill_i,
  input  logic [RES_W-1:0] fill_data_i
);
  logic [KW-1:0]    tag_q  [ENTRIES];
  logic [RES_W-1:0] data_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [IW-1:0]    idx;

  // fold the two operand fields so both spread across the sets
  assign idx = key_i[IW-1:0] ^ key_i[OPW +: IW];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e]  <= 1'b0;
        tag_q[e]  <= '0;
        data_q[e] <= '0;
      end else if (fill_i && idx == IW'(e)) begin
        vld_q[e]  <= 1'b1;
        tag_q[e]  <= key_i;
        data_q[e] <= fill_data_i;
      end
    end
  end

  assign hit_o  = vld_q[idx] && (tag_q[idx] == key_i);
  assign data_o = data_q[idx];
endmodule

// File: rtl/arith_fb_ctrl.sv
module arith_fb_ctrl import arith_fb_pkg::*; #(
  parameter int OPW    = 4,
  parameter int MEM_AW = 16,
  parameter logic [MEM_AW-2*OPW-1:0] ADD_BASE = 'h10,
  parameter logic [MEM_AW-2*OPW-1:0] MUL_BASE = 'h20,
  localparam int RES_W = 2 * OPW,
  localparam int KW    = 1 + 2 * OPW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  fb_op_e            req_op_i,
  input  logic [OPW-1:0]    req_a_i,
  input  logic [OPW-1:0]    req_b_i,
  input  logic [1:0]        unit_off_i,
  input  logic [RES_W-1:0]  native_res_i,
  output logic [KW-1:0]     key_o,
  input  logic              lk_hit_i,
  input  logic [RES_W-1:0]  lk_data_i,
  output logic              fill_o,
  output logic              rsp_valid_o,
  output logic [RES_W-1:0]  rsp_data_o,
  output logic              rsp_lut_o,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [RES_W-1:0]  mem_rdata_i
);
  fb_state_e        st_q;
  logic [KW-1:0]    key_q;
  logic             rsp_valid_q, rsp_lut_q;
  logic [RES_W-1:0] rsp_data_q;
  logic             op_off;
  logic [MEM_AW-2*OPW-1:0] base;

  assign op_off = unit_off_i[req_op_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      key_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_lut_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          key_q <= {req_op_i, req_a_i, req_b_i};
          if (op_off) begin
            st_q <= ST_LOOK;
          end else begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= native_res_i;
            rsp_lut_q   <= 1'b0;
          end
        end
        ST_LOOK: begin
          if (lk_hit_i) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= lk_data_i;
            rsp_lut_q   <= 1'b1;
            st_q        <= ST_IDLE;
          end else begin
            st_q <= ST_MISS;
          end
        end
        ST_MISS: if (mem_rvalid_i) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= mem_rdata_i;
          rsp_lut_q   <= 1'b1;
          st_q        <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign base        = key_q[KW-1] ? MUL_BASE : ADD_BASE;
  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_MISS);
  assign mem_addr_o  = {base, key_q[2*OPW-1:0]};
  assign fill_o      = (st_q == ST_MISS) && mem_rvalid_i;
  assign key_o       = key_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign rsp_lut_o   = rsp_lut_q;
endmodule

// File: rtl/arith_fb.sv
module arith_fb import arith_fb_pkg::*; #(
  parameter int OPW     = 4,
  parameter int ENTRIES = 16,
  parameter int MEM_AW  = 16,
  parameter logic [MEM_AW-2*OPW-1:0] ADD_BASE = 'h10,
  parameter logic [MEM_AW-2*OPW-1:0] MUL_BASE = 'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_op_i,
  input  logic [OPW-1:0]    req_a_i,
  input  logic [OPW-1:0]    req_b_i,
  input  logic [1:0]        unit_hot_i,
  input  logic [1:0]        unit_bad_i,
  output logic              rsp_valid_o,
  output logic [2*OPW-1:0]  rsp_data_o,
  output logic              rsp_lut_o,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [2*OPW-1:0]  mem_rdata_i
);
  localparam int RES_W = 2 * OPW;
  localparam int KW    = 1 + 2 * OPW;

  fb_op_e           op;
  logic [RES_W-1:0] native_res, lk_data;
  logic [KW-1:0]    key;
  logic             lk_hit, fill;

  assign op = fb_op_e'(req_op_i);

  arith_fb_native #(.OPW(OPW)) u_native (
    .op_i(op), .a_i(req_a_i), .b_i(req_b_i), .res_o(native_res)
  );

  arith_fb_tcache #(.OPW(OPW), .ENTRIES(ENTRIES)) u_tcache (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_i(key), .hit_o(lk_hit),
    .data_o(lk_data), .fill_i(fill), .fill_data_i(mem_rdata_i)
  );

  arith_fb_ctrl #(
    .OPW(OPW), .MEM_AW(MEM_AW), .ADD_BASE(ADD_BASE), .MUL_BASE(MUL_BASE)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_op_i(op), .req_a_i(req_a_i), .req_b_i(req_b_i),
    .unit_off_i(unit_hot_i | unit_bad_i), .native_res_i(native_res),
    .key_o(key), .lk_hit_i(lk_hit), .lk_data_i(lk_data), .fill_o(fill),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o), .rsp_lut_o(rsp_lut_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );
endmodule

// File: rtl/arith_fb_chk.sv
module arith_fb_chk #(
  parameter int OPW    = 4,
  parameter int MEM_AW = 16,
  parameter logic [MEM_AW-2*OPW-1:0] ADD_BASE = 'h10,
  parameter logic [MEM_AW-2*OPW-1:0] MUL_BASE = 'h20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_op_i,
  input logic [OPW-1:0]    req_a_i,
  input logic [OPW-1:0]    req_b_i,
  input logic [1:0]        unit_hot_i,
  input logic [1:0]        unit_bad_i,
  input logic              rsp_valid_o,
  input logic [2*OPW-1:0]  rsp_data_o,
  input logic              rsp_lut_o,
  input logic              mem_req_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic [2*OPW-1:0]  mem_rdata_i
);
  logic acc, off;
  assign acc = req_valid_i && req_ready_o;
  assign off = unit_hot_i[req_op_i] | unit_bad_i[req_op_i];

  a_r2_native_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !off |=> rsp_valid_o && !rsp_lut_o && req_ready_o);

  a_r3_native_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !off |=> !mem_req_o);

  a_r5_addr_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[MEM_AW-1:2*OPW] == ADD_BASE) ||
                  (mem_addr_o[MEM_AW-1:2*OPW] == MUL_BASE));

  a_r6_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  a_r6_fill_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i |=> rsp_valid_o && rsp_lut_o && !mem_req_o &&
                                  rsp_data_o == $past(mem_rdata_i));

  a_r9_miss_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o && !rsp_valid_o);

  a_r9_lut_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && off |=> !req_ready_o && !rsp_valid_o);
endmodule

bind arith_fb arith_fb_chk #(
  .OPW(OPW), .MEM_AW(MEM_AW), .ADD_BASE(ADD_BASE), .MUL_BASE(MUL_BASE)
) chk_i (.*);

// File: tb/arith_fb_tb_top.sv
module arith_fb_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_op_i = 1'b0;
  logic [3:0]  req_a_i = '0, req_b_i = '0;
  logic [1:0]  unit_hot_i = '0, unit_bad_i = '0;
  logic        rsp_valid_o, rsp_lut_o, mem_req_o;
  logic [7:0]  rsp_data_o;
  logic [15:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [7:0]  mem_rdata_i = '0;

  int errors = 0, checks = 0;
  logic       m_vld [16];
  logic [8:0] m_tag [16];
  logic [7:0] m_dat [16];

  always #10 clk_i = ~clk_i;

  arith_fb dut_i (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] calc(logic op, logic [3:0] a, logic [3:0] b);
    return op ? ({4'b0, a} * {4'b0, b}) : ({4'b0, a} + {4'b0, b});
  endfunction

  task automatic do_op(logic op, logic [3:0] a, logic [3:0] b,
                       logic [1:0] hot, logic [1:0] bad, int lat, string tg);
    logic off, hit;
    logic [3:0] idx;
    logic [7:0] ev;
    logic [15:0] ea;
    off = hot[op] | bad[op];
    ev  = calc(op, a, b);
    idx = a ^ b;
    ea  = {op ? 8'h20 : 8'h10, a, b};
    @(negedge clk_i);
    check({"R9 ready before accept ", tg}, req_ready_o, 1);
    req_valid_i = 1'b1; req_op_i = op; req_a_i = a; req_b_i = b;
    unit_hot_i = hot; unit_bad_i = bad;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (!off) begin
      check({"R2 native valid ", tg}, rsp_valid_o, 1);
      check({"R2 native data ", tg}, rsp_data_o, ev);
      check({"R4 native path flag ", tg}, rsp_lut_o, 0);
      check({"R3 native no mem ", tg}, mem_req_o, 0);
    end else begin
      check({"R9 busy ready ", tg}, req_ready_o, 0);
      check({"R9 no early rsp ", tg}, rsp_valid_o, 0);
      hit = m_vld[idx] && m_tag[idx] == {op, a, b};
      @(negedge clk_i);
      if (hit) begin
        check({"R7 hit no mem ", tg}, mem_req_o, 0);
        check({"R7 hit valid ", tg}, rsp_valid_o, 1);
        check({"R7 hit data ", tg}, rsp_data_o, m_dat[idx]);
        check({"R7 hit flag ", tg}, rsp_lut_o, 1);
      end else begin
        check({"R6 miss req ", tg}, mem_req_o, 1);
        check({"R5 addr ", tg}, mem_addr_o, ea);
        check({"R9 no rsp during miss ", tg}, rsp_valid_o, 0);
        for (int i = 0; i < lat; i++) begin
          @(negedge clk_i);
          check({"R6 req held ", tg}, {mem_req_o, mem_addr_o}, {1'b1, ea});
        end
        mem_rvalid_i = 1'b1; mem_rdata_i = ev;
        @(negedge clk_i);
        mem_rvalid_i = 1'b0; mem_rdata_i = '0;
        check({"R6 fill valid ", tg}, rsp_valid_o, 1);
        check({"R6 fill data ", tg}, rsp_data_o, ev);
        check({"R6 fill flag ", tg}, rsp_lut_o, 1);
        check({"R6 req dropped ", tg}, mem_req_o, 0);
        check({"R9 ready at rsp ", tg}, req_ready_o, 1);
        m_vld[idx] = 1'b1; m_tag[idx] = {op, a, b}; m_dat[idx] = ev;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin m_vld[i] = 1'b0; m_tag[i] = '0; m_dat[i] = '0; end
    repeat (3) @(negedge clk_i);
    check("R1 reset ready", req_ready_o, 1);
    check("R1 reset rsp", rsp_valid_o, 0);
    check("R1 reset mem", mem_req_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle rsp", rsp_valid_o, 0);

    // R3: native op first, the same operands on the table path must still miss
    do_op(0, 4'd5, 4'd6, 2'b00, 2'b00, 0, "R3 native add");
    do_op(1, 4'd15, 4'd15, 2'b00, 2'b00, 0, "R2 max mul");
    do_op(0, 4'd5, 4'd6, 2'b01, 2'b00, 2, "R1 R3 first lut miss");
    do_op(0, 4'd5, 4'd6, 2'b00, 2'b01, 0, "R4 defect add hit");
    // R4: the other unit's flag does not divert
    do_op(1, 4'd7, 4'd9, 2'b01, 2'b01, 0, "R4 mul unaffected");
    do_op(1, 4'd15, 4'd15, 2'b10, 2'b00, 1, "R4 hot mul");
    // R8: (1,2),(3,0) and mul(1,2) share index 3
    do_op(0, 4'd1, 4'd2, 2'b11, 2'b00, 0, "R8 fill add");
    do_op(0, 4'd1, 4'd2, 2'b11, 2'b00, 0, "R8 rehit add");
    do_op(1, 4'd1, 4'd2, 2'b11, 2'b00, 3, "R8 op conflict");
    do_op(0, 4'd1, 4'd2, 2'b11, 2'b00, 0, "R8 evicted add");
    do_op(0, 4'd3, 4'd0, 2'b11, 2'b00, 1, "R8 operand conflict");
    do_op(1, 4'd15, 4'd15, 2'b10, 2'b00, 0, "R8 other set kept");

    // R10: stray read strobe while idle
    @(negedge clk_i);
    mem_rvalid_i = 1'b1; mem_rdata_i = 8'hEE;
    @(negedge clk_i);
    mem_rvalid_i = 1'b0; mem_rdata_i = '0;
    check("R10 no stray rsp", rsp_valid_o, 0);
    @(negedge clk_i);
    check("R10 no stray rsp later", rsp_valid_o, 0);
    do_op(0, 4'd3, 4'd0, 2'b01, 2'b00, 0, "R10 cache intact");

    for (int n = 0; n < 400; n++) begin
      logic [1:0] hot, bad;
      hot = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      bad = ($urandom % 2 == 0) ? 2'($urandom) : 2'b00;
      do_op(1'($urandom), 4'($urandom), 4'($urandom), hot, bad,
            int'($urandom % 4), "rand");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule